// File: doc/BRIEF.md
# Keyed Configuration Item Read Port

This block gives a host access to a fixed set of configuration items. Each item is a byte string with its own length. The host writes a 16-bit key to pick an item. It then reads the item's bytes one after another through a data register, and each read can be up to `DATA_BYTES` wide. The block holds a cursor made of the current key and a byte offset. It also drives that cursor, the item length and a write-permission flag to a neighbouring DMA engine.

The item table is built inside the block from a fixed formula, so no storage is loaded at run time. Items are held in two banks, and key bit 14 chooses the bank. The parameter `COMBINED` picks one of two access schemes:
- Split scheme: the control register and the data register are separate.
- Combined scheme: a single address serves both, and the block tells select from data by the access size.

A bus access is a one-cycle strobe `req_i` with a size in bytes. The access is accepted or refused in the same cycle (`acc_o`). Read data is combinational in the strobe cycle. The cursor changes at the next rising clock edge.

Top module: `cfg_item_port`

## Requirements
- R1: A synchronous reset selects key 0x0000 with offset 0. After reset, `dma_key_o`=0x0000, `dma_valid_o`=1, `dma_offset_o`=0 and `dma_len_o`=4.
- R2: An accepted select sets the offset to 0 at the next clock edge. A read in the following cycle returns the new item's first byte. This also holds when the same key is selected again.
- R3: Key bit 14 chooses the bank, key bits 13:0 form the index, and bit 15 has no part in the choice. An index of `NUM_ENTRIES` (default 8) or more makes the entry invalid: `dma_key_o`=0xFFFF, `dma_valid_o`=0 and `dma_len_o`=0.
- R4: Item (bank b, index i) has length (i + 2b + 4) mod (`MAX_LEN`+1). Its byte k is (128b + 16i + k + 1) mod 256. An accepted N-byte read returns the next N bytes in the low 8N bits of `rdata_o`, with the first byte in the most significant of those bytes. All bits above are zero.
- R5: When fewer than N bytes are left, the missing low bytes read as zero. The offset advances only by the number of bytes actually supplied.
- R6: A read returns zero and leaves the offset unchanged when the entry is invalid, the item is empty, or the offset has reached the length.
- R7: In the split scheme, the control register (`ctl_i`=1) accepts only 2-byte writes, and each such write selects the key `wdata_i[15:0]`. Control reads and other sizes are refused, return zero and change nothing.
- R8: In the split scheme, the data register accepts accesses only at `off_i`=0, with a size from 1 to `DATA_BYTES`. Writes to it are accepted but change neither the key nor the offset.
- R9: In the combined scheme, `ctl_i` and `off_i` are ignored. A 1-byte read returns data, and a 2-byte write selects. A 1-byte write is accepted and ignored. Every other access is refused and returns zero.
- R10: `dma_wr_ok_o` is 1 only for a valid, non-empty item with an odd index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| ctl_i | input | 1 | Split scheme: 1 = control register, 0 = data register |
| off_i | input | 3 | Byte offset of the access within the register |
| size_i | input | SZ_W (3) | Access size in bytes |
| wdata_i | input | 8*DATA_BYTES (32) | Write data; bits 15:0 carry the key |
| rdata_o | output | 8*DATA_BYTES (32) | Read data, valid in the strobe cycle |
| acc_o | output | 1 | Access accepted |
| dma_key_o | output | 16 | Current key, or 0xFFFF when the entry is invalid |
| dma_valid_o | output | 1 | Current entry is valid |
| dma_offset_o | output | OFF_W (4) | Current byte offset |
| dma_len_o | output | OFF_W (4) | Length of the current item |
| dma_wr_ok_o | output | 1 | Current item may be written by the DMA side |

## Verification
The assertions assume that `req_i` is a clean, single-cycle strobe. They also assume that size, direction and data are stable while the strobe is high, and that the cursor is moved only by accepted selects and reads. The bench drives every input on the falling edge and holds it for one full cycle. It then clears the strobe, so no two accesses overlap. Refused and ignored accesses are sent deliberately, so that the hold-state assertions are exercised on real traffic.

// File: rtl/cfg_item_pkg.sv
package cfg_item_pkg;

    localparam int unsigned KEY_W      = 16;
    localparam int unsigned BANK_BIT   = 14;
    localparam logic [KEY_W-1:0] IDX_MASK = 16'h3FFF;
    localparam logic [KEY_W-1:0] KEY_NONE = 16'hFFFF;

    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_SELECT = 2'd1,
        ACC_READ   = 2'd2,
        ACC_DROP   = 2'd3
    } acc_kind_e;

    // Item length for a bank/index pair.
    function automatic int unsigned item_len_f(input logic bank,
                                               input int unsigned idx,
                                               input int unsigned max_len);
        return (idx + 2 * int'(bank) + 4) % (max_len + 1);
    endfunction

    // Item byte k for a bank/index pair.
    function automatic logic [7:0] item_byte_f(input logic bank,
                                               input int unsigned idx,
                                               input int unsigned k);
        int unsigned v;
        v = 128 * int'(bank) + 16 * idx + k + 1;
        return v[7:0];
    endfunction

    function automatic int unsigned key_index_f(input logic [KEY_W-1:0] key);
        logic [KEY_W-1:0] m;
        m = key & IDX_MASK;
        return int'(m);
    endfunction

endpackage

// File: rtl/cfg_item_decode.sv
module cfg_item_decode
    import cfg_item_pkg::*;
#(
    parameter bit          COMBINED   = 1'b0,
    parameter int unsigned DATA_BYTES = 4,
    parameter int unsigned SZ_W       = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            req_i,
    input  logic            we_i,
    input  logic            ctl_i,
    input  logic [2:0]      off_i,
    input  logic [SZ_W-1:0] size_i,
    output acc_kind_e       kind_o
);

    acc_kind_e kind_raw;
    int unsigned sz;

    assign sz = int'(size_i);

    generate
        if (COMBINED) begin : g_comb
            // Function chosen by access size only.
            logic unused_sel;
            assign unused_sel = ctl_i ^ (|off_i);
            always_comb begin
                kind_raw = ACC_NONE;
                if (sz == 1 && !we_i)      kind_raw = ACC_READ;
                else if (sz == 1 && we_i)  kind_raw = ACC_DROP;
                else if (sz == 2 && we_i)  kind_raw = ACC_SELECT;
            end
        end else begin : g_split
            always_comb begin
                kind_raw = ACC_NONE;
                if (ctl_i) begin
                    if (we_i && sz == 2) kind_raw = ACC_SELECT;
                end else if (off_i == 3'd0 && sz >= 1 && sz <= DATA_BYTES) begin
                    kind_raw = we_i ? ACC_DROP : ACC_READ;
                end
            end
        end
    endgenerate

    assign kind_o = req_i ? kind_raw : ACC_NONE;

    // R7: a control-register read is never taken in the split scheme
    p_ctl_read_refused_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!COMBINED && req_i && ctl_i && !we_i) |-> (kind_o == ACC_NONE));

    // R9: a wide read is never taken in the combined scheme
    p_comb_wide_read_refused_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        (COMBINED && req_i && !we_i && sz != 1) |-> (kind_o == ACC_NONE));

endmodule

// File: rtl/cfg_item_table.sv
module cfg_item_table
    import cfg_item_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned MAX_LEN     = 8,
    parameter int unsigned DATA_BYTES  = 4,
    parameter int unsigned OFF_W       = 4
) (
    input  logic [KEY_W-1:0] key_i,
    input  logic             valid_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [OFF_W-1:0] len_o,
    output logic             wr_ok_o,
    output logic [7:0]       lane_o [DATA_BYTES]
);

    logic        bank;
    int unsigned idx;
    int unsigned len_int;

    assign bank    = key_i[BANK_BIT];
    assign idx     = key_index_f(key_i);
    assign len_int = valid_i ? item_len_f(bank, idx, MAX_LEN) : 0;
    assign len_o   = OFF_W'(len_int);
    assign wr_ok_o = valid_i && (len_int != 0) && (idx % 2 == 1);

    generate
        for (genvar j = 0; j < DATA_BYTES; j++) begin : g_lane
            int unsigned pos;
            assign pos = int'(off_i) + j;
            assign lane_o[j] = (valid_i && pos < len_int)
                             ? item_byte_f(bank, idx, pos) : 8'h00;
        end
    endgenerate

endmodule

// File: rtl/cfg_item_cursor.sv
module cfg_item_cursor
    import cfg_item_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned OFF_W       = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sel_i,
    input  logic [KEY_W-1:0] sel_key_i,
    input  logic             rd_i,
    input  logic [OFF_W-1:0] take_i,
    input  logic [OFF_W-1:0] len_i,
    output logic [KEY_W-1:0] key_o,
    output logic             valid_o,
    output logic [OFF_W-1:0] off_o
);

    logic sel_in_range;
    assign sel_in_range = key_index_f(sel_key_i) < NUM_ENTRIES;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            key_o   <= '0;
            valid_o <= 1'b1;
            off_o   <= '0;
        end else if (sel_i) begin
            key_o   <= sel_in_range ? sel_key_i : KEY_NONE;
            valid_o <= sel_in_range;
            off_o   <= '0;
        end else if (rd_i) begin
            off_o   <= off_o + take_i;
        end
    end

    // R2: every select restarts the stream
    p_sel_clears_off_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        sel_i |=> (off_o == '0));

    // R3: out-of-range index leaves an invalid cursor
    p_bad_idx_invalid_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i && !sel_in_range) |=> (!valid_o && key_o == KEY_NONE));

    // R5: offset never runs beyond the item length
    p_off_in_range_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        valid_o |-> (off_o <= len_i));

    // R6: a read at the end or on an invalid entry does not advance
    p_stall_at_end_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (rd_i && !sel_i && (!valid_o || off_o >= len_i)) |=> $stable(off_o));

    // R8: without select or read the cursor holds
    p_hold_idle_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sel_i && !rd_i) |=> ($stable(off_o) && $stable(key_o)));

endmodule

// File: rtl/cfg_item_port.sv
module cfg_item_port
    import cfg_item_pkg::*;
#(
    parameter bit          COMBINED    = 1'b0,
    parameter int unsigned NUM_ENTRIES = 8,
    parameter int unsigned MAX_LEN     = 8,
    parameter int unsigned DATA_BYTES  = 4,
    parameter int unsigned SZ_W        = $clog2(DATA_BYTES + 1),
    parameter int unsigned OFF_W       = $clog2(MAX_LEN + 1),
    parameter int unsigned DW          = 8 * DATA_BYTES
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             req_i,
    input  logic             we_i,
    input  logic             ctl_i,
    input  logic [2:0]       off_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic             acc_o,
    output logic [KEY_W-1:0] dma_key_o,
    output logic             dma_valid_o,
    output logic [OFF_W-1:0] dma_offset_o,
    output logic [OFF_W-1:0] dma_len_o,
    output logic             dma_wr_ok_o
);

    acc_kind_e        kind;
    logic [KEY_W-1:0] cur_key;
    logic             cur_valid;
    logic [OFF_W-1:0] cur_off;
    logic [OFF_W-1:0] cur_len;
    logic             cur_wr_ok;
    logic [7:0]       lane [DATA_BYTES];
    logic [OFF_W-1:0] take;
    logic [KEY_W-1:0] sel_key;
    logic             sel_fire;
    logic             rd_fire;

    assign sel_key  = KEY_W'(wdata_i);
    assign sel_fire = (kind == ACC_SELECT);
    assign rd_fire  = (kind == ACC_READ);
    assign acc_o    = (kind != ACC_NONE);

    cfg_item_decode #(
        .COMBINED   (COMBINED),
        .DATA_BYTES (DATA_BYTES),
        .SZ_W       (SZ_W)
    ) u_decode (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (req_i),
        .we_i   (we_i),
        .ctl_i  (ctl_i),
        .off_i  (off_i),
        .size_i (size_i),
        .kind_o (kind)
    );

    cfg_item_table #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .MAX_LEN     (MAX_LEN),
        .DATA_BYTES  (DATA_BYTES),
        .OFF_W       (OFF_W)
    ) u_table (
        .key_i   (cur_key),
        .valid_i (cur_valid),
        .off_i   (cur_off),
        .len_o   (cur_len),
        .wr_ok_o (cur_wr_ok),
        .lane_o  (lane)
    );

    cfg_item_cursor #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .OFF_W       (OFF_W)
    ) u_cursor (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .sel_i     (sel_fire),
        .sel_key_i (sel_key),
        .rd_i      (rd_fire),
        .take_i    (take),
        .len_i     (cur_len),
        .key_o     (cur_key),
        .valid_o   (cur_valid),
        .off_o     (cur_off)
    );

    // Bytes actually supplied: min(size, remaining).
    always_comb begin
        int unsigned remain;
        int unsigned sz;
        sz     = int'(size_i);
        remain = (cur_valid && cur_off < cur_len) ? int'(cur_len - cur_off) : 0;
        take   = OFF_W'((sz < remain) ? sz : remain);
    end

    // String-order packing: first byte most significant of the window.
    always_comb begin
        int unsigned sz;
        sz      = int'(size_i);
        rdata_o = '0;
        if (rd_fire) begin
            for (int j = 0; j < DATA_BYTES; j++) begin
                if (j < sz) begin
                    rdata_o = rdata_o | (DW'(lane[j]) << (8 * (sz - 1 - j)));
                end
            end
        end
    end

    assign dma_key_o    = cur_key;
    assign dma_valid_o  = cur_valid;
    assign dma_offset_o = cur_off;
    assign dma_len_o    = cur_len;
    assign dma_wr_ok_o  = cur_wr_ok;

    // R6/R7: anything other than an accepted read returns zero
    p_nonread_zero_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        !rd_fire |-> (rdata_o == '0));

    // R6: an invalid entry never produces data
    p_invalid_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !cur_valid |-> (rdata_o == '0 && dma_len_o == '0));

    // R10: write permission only on a valid non-empty item
    p_wr_ok_valid_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        dma_wr_ok_o |-> (dma_valid_o && dma_len_o != '0));

    // R8: an ignored data write moves nothing
    p_drop_no_effect_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (kind == ACC_DROP) |=> ($stable(dma_offset_o) && $stable(dma_key_o)));

endmodule

// File: tb/test_cfg_item_port.sv
module test_cfg_item_port;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_s, req_c, we, ctl;
    logic [2:0]  off;
    logic [2:0]  size;
    logic [31:0] wdata;
    logic [31:0] rdata_s, rdata_c;
    logic        acc_s, acc_c;
    logic [15:0] key_s, key_c;
    logic        val_s, val_c, wok_s, wok_c;
    logic [3:0]  doff_s, doff_c, dlen_s, dlen_c;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_item_port #(.COMBINED(1'b0)) i_cfg_item_port (
        .clk_i(clk), .rst_i(rst), .req_i(req_s), .we_i(we), .ctl_i(ctl),
        .off_i(off), .size_i(size), .wdata_i(wdata), .rdata_o(rdata_s),
        .acc_o(acc_s), .dma_key_o(key_s), .dma_valid_o(val_s),
        .dma_offset_o(doff_s), .dma_len_o(dlen_s), .dma_wr_ok_o(wok_s));

    cfg_item_port #(.COMBINED(1'b1)) i_cfg_item_port_comb (
        .clk_i(clk), .rst_i(rst), .req_i(req_c), .we_i(we), .ctl_i(ctl),
        .off_i(off), .size_i(size), .wdata_i(wdata), .rdata_o(rdata_c),
        .acc_o(acc_c), .dma_key_o(key_c), .dma_valid_o(val_c),
        .dma_offset_o(doff_c), .dma_len_o(dlen_c), .dma_wr_ok_o(wok_c));

    // {op(0 sel,1 read), key or size, expected data}
    localparam logic [49:0] VEC [NVEC] = '{
        {2'd1, 16'd1,      32'h0000_0001},
        {2'd1, 16'd2,      32'h0000_0203},
        {2'd1, 16'd4,      32'h0400_0000},
        {2'd1, 16'd1,      32'h0000_0000},
        {2'd0, 16'h0002,   32'h0},
        {2'd1, 16'd4,      32'h2122_2324},
        {2'd1, 16'd4,      32'h2526_0000},
        {2'd0, 16'h4001,   32'h0},
        {2'd1, 16'd3,      32'h0091_9293},
        {2'd0, 16'h0005,   32'h0},
        {2'd1, 16'd2,      32'h0000_0000},
        {2'd0, 16'h0008,   32'h0},
        {2'd1, 16'd1,      32'h0000_0000},
        {2'd0, 16'h8001,   32'h0},
        {2'd1, 16'd4,      32'h1112_1314},
        {2'd0, 16'h4004,   32'h0},
        {2'd1, 16'd2,      32'h0000_C100}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access: drive at falling edge, sample mid-cycle, release after the edge.
    task automatic access(input bit comb, input bit c, input bit w, input logic [2:0] o,
                          input logic [2:0] s, input logic [31:0] d,
                          output logic [31:0] rd, output logic ac);
        @(negedge clk);
        ctl = c; we = w; off = o; size = s; wdata = d;
        if (comb) req_c = 1'b1; else req_s = 1'b1;
        #1;
        rd = comb ? rdata_c : rdata_s;
        ac = comb ? acc_c : acc_s;
        @(posedge clk);
        #1;
        req_s = 1'b0; req_c = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic ac;
        rst = 1'b1; req_s = 0; req_c = 0; we = 0; ctl = 0; off = 0; size = 0; wdata = 0;
        repeat (2) @(posedge clk);
        do_reset();

        // R1 reset state
        check("R1 key",    {16'h0, key_s}, 32'h0);
        check("R1 valid",  {31'h0, val_s}, 32'h1);
        check("R1 offset", {28'h0, doff_s}, 32'h0);
        check("R1 len",    {28'h0, dlen_s}, 32'h4);

        // Vector walk on split scheme (R3 R4 R5 R6)
        for (int i = 0; i < NVEC; i++) begin
            logic [49:0] v;
            v = VEC[i];
            if (v[49:48] == 2'd0) begin
                access(0, 1, 1, 3'd0, 3'd2, {16'h0, v[47:32]}, rd, ac);
                check($sformatf("R3 select vec %0d acc", i), {31'h0, ac}, 32'h1);
            end else begin
                access(0, 0, 0, 3'd0, v[34:32], 32'h0, rd, ac);
                check($sformatf("R4 R5 R6 read vec %0d", i), rd, v[31:0]);
            end
        end

        // R3 invalid index outputs, checked after a select of 0x0008
        access(0, 1, 1, 3'd0, 3'd2, 32'h0008, rd, ac);
        check("R3 invalid key", {16'h0, key_s}, 32'h0000_FFFF);
        check("R3 invalid valid", {31'h0, val_s}, 32'h0);
        check("R3 invalid len", {28'h0, dlen_s}, 32'h0);

        // R10 dma outputs
        access(0, 1, 1, 3'd0, 3'd2, 32'h4001, rd, ac);
        check("R10 key", {16'h0, key_s}, 32'h4001);
        check("R10 len", {28'h0, dlen_s}, 32'h7);
        check("R10 wr_ok odd", {31'h0, wok_s}, 32'h1);
        access(0, 1, 1, 3'd0, 3'd2, 32'h0002, rd, ac);
        check("R10 wr_ok even", {31'h0, wok_s}, 32'h0);

        // R2 reselect restarts
        access(0, 0, 0, 3'd0, 3'd2, 32'h0, rd, ac);
        check("R2 first read", rd, 32'h2122);
        access(0, 1, 1, 3'd0, 3'd2, 32'h0002, rd, ac);
        check("R2 offset cleared", {28'h0, doff_s}, 32'h0);
        access(0, 0, 0, 3'd0, 3'd1, 32'h0, rd, ac);
        check("R2 restart byte", rd, 32'h21);

        // R7 control register
        access(0, 1, 0, 3'd0, 3'd2, 32'h0, rd, ac);
        check("R7 ctl read acc", {31'h0, ac}, 32'h0);
        check("R7 ctl read data", rd, 32'h0);
        access(0, 1, 1, 3'd0, 3'd1, 32'h0001, rd, ac);
        check("R7 ctl 1-byte write acc", {31'h0, ac}, 32'h0);
        check("R7 ctl 1-byte write key", {16'h0, key_s}, 32'h0002);
        check("R7 ctl 1-byte write offset", {28'h0, doff_s}, 32'h1);

        // R8 data register
        access(0, 0, 0, 3'd1, 3'd1, 32'h0, rd, ac);
        check("R8 nonzero offset acc", {31'h0, ac}, 32'h0);
        check("R8 nonzero offset data", rd, 32'h0);
        access(0, 0, 1, 3'd0, 3'd1, 32'h0000_4001, rd, ac);
        check("R8 data write acc", {31'h0, ac}, 32'h1);
        check("R8 data write offset", {28'h0, doff_s}, 32'h1);
        check("R8 data write key", {16'h0, key_s}, 32'h0002);
        access(0, 0, 0, 3'd0, 3'd1, 32'h0, rd, ac);
        check("R8 next byte", rd, 32'h22);

        // R9 combined scheme
        access(1, 0, 0, 3'd0, 3'd1, 32'h0, rd, ac);
        check("R9 comb 1-byte read", rd, 32'h01);
        access(1, 1, 1, 3'd5, 3'd2, 32'h0002, rd, ac);
        check("R9 comb 2-byte write acc", {31'h0, ac}, 32'h1);
        check("R9 comb select key", {16'h0, key_c}, 32'h0002);
        access(1, 0, 1, 3'd0, 3'd1, 32'h0004, rd, ac);
        check("R9 comb 1-byte write acc", {31'h0, ac}, 32'h1);
        check("R9 comb 1-byte write key", {16'h0, key_c}, 32'h0002);
        access(1, 0, 0, 3'd0, 3'd2, 32'h0, rd, ac);
        check("R9 comb 2-byte read acc", {31'h0, ac}, 32'h0);
        check("R9 comb 2-byte read data", rd, 32'h0);
        access(1, 1, 0, 3'd3, 3'd1, 32'h0, rd, ac);
        check("R9 comb read byte", rd, 32'h21);

        // R1 reset again mid-stream
        do_reset();
        check("R1 re-reset key", {16'h0, key_s}, 32'h0);
        check("R1 re-reset offset", {28'h0, doff_s}, 32'h0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule